// File: doc/BRIEF.md
# Multi-Channel Rotating Sine Generator

The block produces sine samples for a set of independent channels while owning only one phase-to-amplitude datapath. A channel counter steps down from a configured top index to zero and then starts over. On each step the selected channel's stored phase accumulator and its configuration are read. The phase, formed from the accumulator plus a per-channel offset, goes through a quarter-wave sine table, a fixed-point scale multiply and an integer offset add. The sample then leaves on a stream output tagged with the channel number. There is no ready input, so a sample is emitted every clock cycle.

Each channel has three configuration entries, held in tables addressed by channel number. The first holds the phase step. The second holds the phase offset and an accumulator-clear flag. The third holds an unsigned scale factor and a signed output offset. Software writes and reads these entries through a simple register port: a write strobe, a table select and an address. Reads are combinational.

Top module: `mcsg_top`

## Requirements
- R1: `m_tuser` of successive valid samples follows TABLE_TOP, TABLE_TOP-1, ..., 0, TABLE_TOP, ... (default TABLE_TOP = 5).
- R2: `m_tvalid` is 0 while `rst` is high and for the first two cycles after release. From the third rising edge after release it is 1 on every cycle, and the first sample carries `m_tuser` = TABLE_TOP.
- R3: After reset, every channel's accumulator is 0. The phase of a sample is (accumulator + phase offset) mod 256, taken before the visit. Each visit then adds the phase step, mod 256.
- R4: When bit 8 of a channel's offset entry (select 1) is 1, a visit stores 0 in that channel's accumulator instead of advancing it.
- R5: The sine value for phase p is computed as follows. Let m = p mod 128, k = m when m < 64, else 127 - m, x = 2k+1 and t = x(256-x). The magnitude is floor(511·16·t / (5·65536 - 4t)). The sine value is negative when p >= 128.
- R6: `m_tdata` = floor((sine · S + O · 64) / 64), sign-extended to 16 bits. S is the unsigned scale in bits [7:0] of the select-2 entry, with 6 fractional bits. O is the signed offset in bits [15:8] of the same entry.
- R7: Table selects are 0 (phase step, bits [7:0]), 1 (phase offset in bits [7:0], clear flag in bit 8) and 2 (scale in bits [7:0], offset in bits [15:8]). A read returns the stored fields, and all other bits read 0.
- R8: A write with select 3 changes no table, and a read with select 3 returns 0.
- R9: A synchronous reset clears every accumulator and the output valid, and restarts the index at TABLE_TOP. Table contents are kept through reset and may be written while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_wsel | input | 2 | Table select for the write |
| cfg_waddr | input | W_IDX | Channel entry to write |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 2 | Table select for the read |
| cfg_raddr | input | W_IDX | Channel entry to read |
| cfg_rdata | output | 32 | Read data, combinational |
| m_tvalid | output | 1 | Sample strobe |
| m_tdata | output | W_OUT | Signed sample |
| m_tuser | output | W_IDX | Channel index of the sample |

## Verification
Three register stages separate the index counter from the output. The sample for the index that is current in one cycle therefore appears after the third rising edge that follows. The bench checks the valid strobe after the first, second and third edges after release, and then checks one sample per cycle. A table write lands on the rising edge between two falling edges. The combinational read of that entry is checked at the following falling edge. All outputs are sampled on falling edges, half a period away from the rising edge that updates them.

// File: rtl/mcsg_pkg.sv
package mcsg_pkg;
   typedef enum logic [1:0] {
      TBL_STEP  = 2'd0,
      TBL_PHOFS = 2'd1,
      TBL_SCALE = 2'd2,
      TBL_NONE  = 2'd3
   } tbl_sel_e;
endpackage

// File: rtl/mcsg_regfile.sv
module mcsg_regfile
   import mcsg_pkg::*;
#(
   parameter int W_IDX    = 3,
   parameter int W_PHASE  = 8,
   parameter int W_SCALE  = 8,
   parameter int W_OFFSET = 8
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [1:0]                 wsel,
   input  logic [W_IDX-1:0]           waddr,
   input  logic [31:0]                wdata,
   input  logic [1:0]                 rsel,
   input  logic [W_IDX-1:0]           raddr,
   output logic [31:0]                rdata,
   input  logic [W_IDX-1:0]           lidx,
   output logic [W_PHASE-1:0]         l_step,
   output logic [W_PHASE-1:0]         l_phofs,
   output logic                       l_clr,
   output logic [W_SCALE-1:0]         l_scale,
   output logic signed [W_OFFSET-1:0] l_offset
);
   localparam int N_ENT = 2 ** W_IDX;

   logic [W_PHASE-1:0]  step_t  [N_ENT];
   logic [W_PHASE-1:0]  phofs_t [N_ENT];
   logic                clr_t   [N_ENT];
   logic [W_SCALE-1:0]  scale_t [N_ENT];
   logic [W_OFFSET-1:0] off_t   [N_ENT];

   always_ff @(posedge clk) begin
      if (we) begin
         case (tbl_sel_e'(wsel))
            TBL_STEP:  step_t[waddr] <= wdata[W_PHASE-1:0];
            TBL_PHOFS: begin
               phofs_t[waddr] <= wdata[W_PHASE-1:0];
               clr_t[waddr]   <= wdata[W_PHASE];
            end
            TBL_SCALE: begin
               scale_t[waddr] <= wdata[W_SCALE-1:0];
               off_t[waddr]   <= wdata[W_SCALE+W_OFFSET-1:W_SCALE];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (tbl_sel_e'(rsel))
         TBL_STEP:  rdata = 32'(step_t[raddr]);
         TBL_PHOFS: rdata = 32'({clr_t[raddr], phofs_t[raddr]});
         TBL_SCALE: rdata = 32'({off_t[raddr], scale_t[raddr]});
         default:   rdata = '0;
      endcase
   end

   assign l_step   = step_t[lidx];
   assign l_phofs  = phofs_t[lidx];
   assign l_clr    = clr_t[lidx];
   assign l_scale  = scale_t[lidx];
   assign l_offset = signed'(off_t[lidx]);
endmodule

// File: rtl/mcsg_sine_lut.sv
module mcsg_sine_lut #(
   parameter int W_PHASE = 8,
   parameter int W_AMP   = 10
) (
   input  logic [W_PHASE-1:0]      phase,
   output logic signed [W_AMP-1:0] sine
);
   localparam int QB = W_PHASE - 2;
   localparam int Q  = 2 ** QB;

   // Rational sine approximation on half-step sample points of one quarter.
   function automatic logic [W_AMP-2:0] quarter_val(int k);
      longint x, p, t, a;
      x = 2 * longint'(k) + 1;
      p = 4 * longint'(Q);
      t = x * (p - x);
      a = (longint'(1) <<< (W_AMP - 1)) - 1;
      return (W_AMP-1)'((a * 16 * t) / (5 * p * p - 4 * t));
   endfunction

   logic [W_AMP-2:0] qtab [Q];
   for (genvar k = 0; k < Q; k++) begin : g_qtab
      assign qtab[k] = quarter_val(k);
   end

   logic          neg_half;
   logic          mirror;
   logic [QB-1:0] qidx;
   logic [W_AMP-2:0] mag;

   assign neg_half = phase[W_PHASE-1];
   assign mirror   = phase[W_PHASE-2];
   assign qidx     = mirror ? ~phase[QB-1:0] : phase[QB-1:0];
   assign mag      = qtab[qidx];
   assign sine     = neg_half ? -signed'({1'b0, mag}) : signed'({1'b0, mag});
endmodule

// File: rtl/mcsg_scaler.sv
module mcsg_scaler #(
   parameter int W_AMP    = 10,
   parameter int W_SCALE  = 8,
   parameter int FRAC     = 6,
   parameter int W_OFFSET = 8,
   parameter int W_IDX    = 3,
   parameter int W_OUT    = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_vld,
   input  logic [W_IDX-1:0]           in_idx,
   input  logic signed [W_AMP-1:0]    sine,
   input  logic [W_SCALE-1:0]         scale,
   input  logic signed [W_OFFSET-1:0] offset,
   output logic                       out_vld,
   output logic [W_IDX-1:0]           out_idx,
   output logic [W_OUT-1:0]           out_data
);
   localparam int PW = W_AMP + W_SCALE + 1;
   localparam int SW = PW + 1;
   localparam int IW = SW - FRAC;

   logic signed [SW-1:0] sine_x, scale_x, off_x, prod, sum;
   logic signed [IW-1:0] whole;

   assign sine_x  = SW'(sine);
   assign scale_x = signed'(SW'(scale));
   assign off_x   = SW'(offset) <<< FRAC;
   assign prod    = sine_x * scale_x;
   assign sum     = prod + off_x;
   assign whole   = sum[SW-1:FRAC];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_idx  <= '0;
         out_data <= '0;
      end else begin
         out_vld  <= in_vld;
         out_idx  <= in_idx;
         out_data <= {{(W_OUT-IW){whole[IW-1]}}, whole};
      end
   end
endmodule

// File: rtl/mcsg_top.sv
module mcsg_top #(
   parameter int W_IDX     = 3,
   parameter int TABLE_TOP = 5,
   parameter int W_PHASE   = 8,
   parameter int W_AMP     = 10,
   parameter int W_SCALE   = 8,
   parameter int FRAC      = 6,
   parameter int W_OFFSET  = 8,
   parameter int W_OUT     = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_wsel,
   input  logic [W_IDX-1:0]   cfg_waddr,
   input  logic [31:0]        cfg_wdata,
   input  logic [1:0]         cfg_rsel,
   input  logic [W_IDX-1:0]   cfg_raddr,
   output logic [31:0]        cfg_rdata,
   output logic               m_tvalid,
   output logic [W_OUT-1:0]   m_tdata,
   output logic [W_IDX-1:0]   m_tuser
);
   localparam int N_ENT = 2 ** W_IDX;
   localparam logic [W_IDX-1:0] TOP_IDX = W_IDX'(TABLE_TOP);

   if (TABLE_TOP < 0 || TABLE_TOP >= N_ENT) begin : g_bad_top
      $error("TABLE_TOP must fit in W_IDX bits");
   end
   if (W_PHASE < 3 || W_PHASE + 1 > 32) begin : g_bad_phase
      $error("W_PHASE out of range");
   end
   if (W_SCALE + W_OFFSET > 32 || FRAC >= W_SCALE + W_AMP) begin : g_bad_scale
      $error("scale/offset fields do not fit");
   end
   if (W_OUT <= W_AMP + W_SCALE + 2 - FRAC) begin : g_bad_out
      $error("W_OUT too narrow for the scaled result");
   end

   // Index sequencer: counts down and wraps to the top entry.
   logic [W_IDX-1:0] cur_idx;
   always_ff @(posedge clk) begin
      if (rst)               cur_idx <= TOP_IDX;
      else if (cur_idx == '0) cur_idx <= TOP_IDX;
      else                    cur_idx <= cur_idx - 1'b1;
   end

   logic [W_PHASE-1:0]         c_step, c_phofs;
   logic                       c_clr;
   logic [W_SCALE-1:0]         c_scale;
   logic signed [W_OFFSET-1:0] c_offset;

   mcsg_regfile #(
      .W_IDX(W_IDX), .W_PHASE(W_PHASE), .W_SCALE(W_SCALE), .W_OFFSET(W_OFFSET)
   ) u_regs (
      .clk(clk), .we(cfg_we), .wsel(cfg_wsel), .waddr(cfg_waddr), .wdata(cfg_wdata),
      .rsel(cfg_rsel), .raddr(cfg_raddr), .rdata(cfg_rdata),
      .lidx(cur_idx), .l_step(c_step), .l_phofs(c_phofs), .l_clr(c_clr),
      .l_scale(c_scale), .l_offset(c_offset)
   );

   // Per-channel accumulators.
   logic [W_PHASE-1:0] acc_mem [N_ENT];
   logic [W_PHASE-1:0] acc_now;
   assign acc_now = acc_mem[cur_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N_ENT; i++) acc_mem[i] <= '0;
      end else begin
         acc_mem[cur_idx] <= c_clr ? '0 : acc_now + c_step;
      end
   end

   // Stage 1: phase and channel parameters.
   logic                       s1_vld;
   logic [W_IDX-1:0]           s1_idx;
   logic [W_PHASE-1:0]         s1_phase;
   logic [W_SCALE-1:0]         s1_scale;
   logic signed [W_OFFSET-1:0] s1_off;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld   <= 1'b0;
         s1_idx   <= '0;
         s1_phase <= '0;
         s1_scale <= '0;
         s1_off   <= '0;
      end else begin
         s1_vld   <= 1'b1;
         s1_idx   <= cur_idx;
         s1_phase <= acc_now + c_phofs;
         s1_scale <= c_scale;
         s1_off   <= c_offset;
      end
   end

   // Stage 2: sine lookup.
   logic signed [W_AMP-1:0] s1_sine;
   mcsg_sine_lut #(.W_PHASE(W_PHASE), .W_AMP(W_AMP)) u_lut (
      .phase(s1_phase), .sine(s1_sine)
   );

   logic                       s2_vld;
   logic [W_IDX-1:0]           s2_idx;
   logic signed [W_AMP-1:0]    s2_sine;
   logic [W_SCALE-1:0]         s2_scale;
   logic signed [W_OFFSET-1:0] s2_off;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_vld   <= 1'b0;
         s2_idx   <= '0;
         s2_sine  <= '0;
         s2_scale <= '0;
         s2_off   <= '0;
      end else begin
         s2_vld   <= s1_vld;
         s2_idx   <= s1_idx;
         s2_sine  <= s1_sine;
         s2_scale <= s1_scale;
         s2_off   <= s1_off;
      end
   end

   // Stage 3: scale, offset, truncate.
   mcsg_scaler #(
      .W_AMP(W_AMP), .W_SCALE(W_SCALE), .FRAC(FRAC), .W_OFFSET(W_OFFSET),
      .W_IDX(W_IDX), .W_OUT(W_OUT)
   ) u_scale (
      .clk(clk), .rst(rst), .in_vld(s2_vld), .in_idx(s2_idx), .sine(s2_sine),
      .scale(s2_scale), .offset(s2_off),
      .out_vld(m_tvalid), .out_idx(m_tuser), .out_data(m_tdata)
   );
endmodule

// File: rtl/mcsg_chk.sv
module mcsg_chk #(
   parameter int W_IDX     = 3,
   parameter int TABLE_TOP = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             m_tvalid,
   input logic [W_IDX-1:0] m_tuser
);
   localparam logic [W_IDX-1:0] TOP_IDX = W_IDX'(TABLE_TOP);

   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   a_r1_countdown: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && $past(m_tvalid)) |->
         (m_tuser == (($past(m_tuser) == '0) ? TOP_IDX : $past(m_tuser) - 1'b1)));

   a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
      m_tvalid |-> (m_tuser <= TOP_IDX));

   a_r2_first_is_top: assert property (@(posedge clk) disable iff (rst)
      $rose(m_tvalid) |-> (m_tuser == TOP_IDX));

   a_r2_no_stall: assert property (@(posedge clk) disable iff (rst)
      m_tvalid |=> m_tvalid);

   a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 2'd3) |-> !m_tvalid);

   a_r2_valid_due: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> m_tvalid);
endmodule

bind mcsg_top mcsg_chk #(.W_IDX(W_IDX), .TABLE_TOP(TABLE_TOP)) u_chk (
   .clk(clk), .rst(rst), .m_tvalid(m_tvalid), .m_tuser(m_tuser)
);

// File: tb/tb_mcsg_top.sv
module tb_mcsg_top;
   localparam int W_IDX = 3;
   localparam int TOP   = 5;
   localparam int W_OUT = 16;
   localparam int NSAMP = 40;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_wsel = 2'd0, cfg_rsel = 2'd0;
   logic [W_IDX-1:0] cfg_waddr = '0, cfg_raddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic m_tvalid;
   logic [W_OUT-1:0] m_tdata;
   logic [W_IDX-1:0] m_tuser;

   always #10 clk = ~clk;

   mcsg_top dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_waddr(cfg_waddr),
      .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_raddr(cfg_raddr),
      .cfg_rdata(cfg_rdata), .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tuser(m_tuser)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // Stimulus vectors: [set][channel]
   localparam int V_STEP [2][6] = '{'{3, 17, 64, 1, 200, 255}, '{128, 5, 9, 0, 77, 255}};
   localparam int V_PHOF [2][6] = '{'{0, 10, 100, 255, 7, 33}, '{20, 0, 60, 128, 250, 1}};
   localparam int V_CLR  [2][6] = '{'{0, 0, 0, 0, 0, 0},        '{1, 0, 0, 0, 1, 0}};
   localparam int V_SCL  [2][6] = '{'{64, 64, 32, 128, 255, 10}, '{255, 64, 1, 200, 100, 0}};
   localparam int V_OFF  [2][6] = '{'{0, 0, -3, 5, 0, -128},     '{-128, 127, 0, -1, 40, 9}};

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int sine_ref(int ph);
      int m, k;
      longint x, t, mag;
      m = ph % 128;
      k = (m < 64) ? m : 127 - m;
      x = 2 * longint'(k) + 1;
      t = x * (256 - x);
      mag = (511 * 16 * t) / (5 * 65536 - 4 * t);
      return (ph >= 128) ? -int'(mag) : int'(mag);
   endfunction

   function automatic int out_ref(int s, int scale, int off);
      int v;
      v = s * scale + off * 64;
      if (v >= 0) return v / 64;
      return -((-v + 63) / 64);
   endfunction

   task automatic wr(input int sel, input int addr, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wsel = 2'(sel); cfg_waddr = W_IDX'(addr); cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input int sel, input int addr, output logic [31:0] data);
      cfg_rsel = 2'(sel); cfg_raddr = W_IDX'(addr);
      #1;
      data = cfg_rdata;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rv;
      int acc [8];
      int ch;
      repeat (3) @(negedge clk);
      check("R2 tvalid in reset", int'(m_tvalid), 0);

      // Register field layout and masking
      wr(0, 6, 32'hFFFF_FFFF);
      wr(1, 6, 32'hFFFF_FFFF);
      wr(2, 6, 32'hFFFF_FFFF);
      rd(0, 6, rv); check("R7 step readback", int'(rv), 32'h0000_00FF);
      rd(1, 6, rv); check("R7 phofs readback", int'(rv), 32'h0000_01FF);
      rd(2, 6, rv); check("R7 scale readback", int'(rv), 32'h0000_FFFF);
      wr(3, 6, 32'h0000_0000);
      rd(0, 6, rv); check("R8 step untouched", int'(rv), 32'h0000_00FF);
      rd(1, 6, rv); check("R8 phofs untouched", int'(rv), 32'h0000_01FF);
      rd(2, 6, rv); check("R8 scale untouched", int'(rv), 32'h0000_FFFF);
      rd(3, 6, rv); check("R8 select 3 reads zero", int'(rv), 0);

      for (int set = 0; set < 2; set++) begin
         @(negedge clk);
         rst = 1'b1;
         for (int c = 0; c <= TOP; c++) begin
            wr(0, c, 32'(V_STEP[set][c]));
            wr(1, c, 32'(V_PHOF[set][c] | (V_CLR[set][c] << 8)));
            wr(2, c, 32'(V_SCL[set][c] | ((V_OFF[set][c] & 255) << 8)));
         end
         check("R9 tvalid cleared by reset", int'(m_tvalid), 0);
         rd(1, 0, rv); check("R9 R7 table kept", int'(rv), V_PHOF[set][0] | (V_CLR[set][0] << 8));
         for (int i = 0; i < 8; i++) acc[i] = 0;
         rst = 1'b0;
         @(negedge clk); check("R2 tvalid after edge 1", int'(m_tvalid), 0);
         @(negedge clk); check("R2 tvalid after edge 2", int'(m_tvalid), 0);
         @(negedge clk);
         ch = TOP;
         for (int s = 0; s < NSAMP; s++) begin
            int ph, exp;
            if (s > 0) @(negedge clk);
            ph  = (acc[ch] + V_PHOF[set][ch]) % 256;
            exp = out_ref(sine_ref(ph), V_SCL[set][ch], V_OFF[set][ch]);
            check("R2 tvalid steady", int'(m_tvalid), 1);
            check("R1 tuser order", int'(m_tuser), ch);
            if (V_CLR[set][ch] != 0)
               check("R4 cleared channel tdata", int'($signed(m_tdata)), exp);
            else if (set == 1)
               check("R9 R3 R5 R6 tdata after re-reset", int'($signed(m_tdata)), exp);
            else
               check("R3 R5 R6 tdata", int'($signed(m_tdata)), exp);
            acc[ch] = (V_CLR[set][ch] != 0) ? 0 : (acc[ch] + V_STEP[set][ch]) % 256;
            ch = (ch == 0) ? TOP : ch - 1;
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule